// File: doc/BRIEF.md
# Edge Timestamp Encoder with Deskew

This block takes one registered snapshot of a tapped delay line per clock and turns each input transition it contains into a complete fixed-point timestamp. Tap 0 is the tap nearest the injection point, and a transition spreads from there towards the far end of the line. The block finds the clock in which the input changed. It counts the taps that already carry the new level, which is the raw fine position inside that clock period. It sends this count out on a lookup port and receives back a calibrated fraction of the clock period. That fraction is appended below a free-running count of clock cycles, and a programmable offset is then added. The result leaves the block with a polarity flag and a one-cycle valid strobe.

Tracking is controlled by a two-state machine. `ST_PRIME` is held while reset is asserted. It lasts exactly one clock after reset is released and only records the level seen at tap 0. On that clock the machine takes the transition `PRIME_TO_TRACK`. `ST_TRACK` compares every later snapshot with the level recorded one clock earlier. It leaves only through reset, and its self-loop is the transition `TRACK_HOLD`. The delay line is built from carry elements of four taps each, so the tap width is always four times the element count. The calibration table lives outside the block and returns data a fixed `LUT_LAT` clocks after each address.

Top module: `edge_timestamper`

## Requirements
- R1: After reset is released, the first snapshot only primes the reference level and never yields a timestamp. `lut_req_o` stays low for that clock, and `ts_valid_o` stays low until at least `LUT_LAT+3` clocks after release.
- R2: In tracking, an edge is detected exactly when `taps_i[0]` differs from its value in the previous snapshot. Changes on other taps while tap 0 holds its level produce neither a lookup request nor a timestamp.
- R3: `ts_pol_o` gives the new level of tap 0 for the edge being reported: 1 for a rising edge, 0 for a falling edge.
- R4: One clock after the edge snapshot, `lut_req_o` is high and `lut_addr_o` equals the number of taps in that snapshot that hold the new level. Bubbles are counted individually, and the value lies between 1 and `TAP_W`.
- R5: The integer field of the timestamp (bits `TS_W-1:FRAC_W` before the offset is added) is the coarse count of the snapshot clock. This count is 0 for the first clock edge after reset release and rises by one per clock.
- R6: The fraction field (bits `FRAC_W-1:0` before the offset is added) is the `lut_data_i` value that returns `LUT_LAT` clocks after the address.
- R7: `ts_o` equals {coarse, fraction} plus `offset_i`, modulo 2^`TS_W`. `offset_i` is sampled on the clock that produces the timestamp.
- R8: `ts_valid_o` is high for exactly one clock, `LUT_LAT+1` clock edges after the edge at which the snapshot was captured.
- R9: Edges in consecutive clocks each yield their own timestamp, in order, on consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| taps_i | input | TAP_W | Registered delay-line snapshot; bit 0 nearest the injection point |
| offset_i | input | TS_W | Deskew constant added to each timestamp |
| lut_addr_o | output | RAW_W | Raw tap count sent to the calibration table |
| lut_req_o | output | 1 | Marks a lookup that belongs to a detected edge |
| lut_data_i | input | FRAC_W | Calibrated fraction, returned LUT_LAT clocks after the address |
| ts_o | output | TS_W | Timestamp: coarse cycles above FRAC_W fraction bits, plus offset |
| ts_pol_o | output | 1 | Edge polarity, 1 for rising |
| ts_valid_o | output | 1 | One-clock strobe for each timestamp |

## Verification
A reference level that is stale or wrong shows up within one clock: a spurious lookup request or a missing one appears, and then a timestamp arrives `LUT_LAT+1` clocks later or fails to arrive. An error in the tap count appears at once on `lut_addr_o`, and through the table it corrupts the low field of the timestamp. A coarse counter or alignment pipeline that is off by even one stage moves the integer field or the fraction of every later timestamp, or shifts the strobe by a clock. The integer field of each timestamp is therefore compared with the clock index the bench tracks itself, and the strobe must land on one exact clock.

// File: rtl/tsenc_pkg.sv
package tsenc_pkg;

    // Tracking state of the edge detector
    typedef enum logic [0:0] {
        ST_PRIME = 1'b0,   // first snapshot after reset: record level only
        ST_TRACK = 1'b1    // compare each snapshot with the recorded level
    } trk_state_e;

    // Number of taps contributed by one carry element
    localparam int TAPS_PER_ELEM = 4;

endpackage

// File: rtl/tsenc_edge.sv
module tsenc_edge
    import tsenc_pkg::*;
#(
    parameter int TAP_W = 32,
    parameter int RAW_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAP_W-1:0] taps_i,
    output logic             hit_o,
    output logic             pol_o,
    output logic [RAW_W-1:0] raw_o
);

    trk_state_e       state_q;
    trk_state_e       state_d;
    logic             ref_q;
    logic             edge_now;
    logic [TAP_W-1:0] moved;
    logic [RAW_W-1:0] reach;

    // Next-state logic: PRIME_TO_TRACK after one clock, TRACK_HOLD afterwards
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME: state_d = ST_TRACK;
            ST_TRACK: state_d = ST_TRACK;
            default:  state_d = ST_PRIME;
        endcase
    end

    // Edge decision and tap population count (tolerant of bubbles)
    always_comb begin
        edge_now = (state_q == ST_TRACK) && (taps_i[0] != ref_q);
        moved    = taps_i ^ {TAP_W{ref_q}};
        reach    = '0;
        for (int i = 0; i < TAP_W; i++) begin
            reach = reach + RAW_W'(moved[i]);
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PRIME;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs and reference level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q <= 1'b0;
            hit_o <= 1'b0;
            pol_o <= 1'b0;
            raw_o <= '0;
        end else begin
            ref_q <= taps_i[0];
            hit_o <= edge_now;
            pol_o <= taps_i[0];
            raw_o <= edge_now ? reach : '0;
        end
    end

endmodule

// File: rtl/tsenc_coarse.sv
module tsenc_coarse #(
    parameter int CNT_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] snap_o
);

    logic [CNT_W-1:0] count_q;

    // Free-running cycle count; snap_o lines up with the edge stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            snap_o  <= '0;
        end else begin
            count_q <= count_q + 1'b1;
            snap_o  <= count_q;
        end
    end

endmodule

// File: rtl/tsenc_align.sv
module tsenc_align #(
    parameter int DATA_W = 27,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] d_i,
    output logic [DATA_W-1:0] q_o
);

    logic [DATA_W-1:0] stage_q [DEPTH];

    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_stage
            if (s == 0) begin : g_head
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= d_i;
                end
            end else begin : g_body
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[DEPTH-1];

endmodule

// File: rtl/tsenc_assemble.sv
module tsenc_assemble #(
    parameter int COARSE_W = 25,
    parameter int FRAC_W   = 13,
    localparam int TS_W    = COARSE_W + FRAC_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hit_i,
    input  logic                pol_i,
    input  logic [COARSE_W-1:0] coarse_i,
    input  logic [FRAC_W-1:0]   frac_i,
    input  logic [TS_W-1:0]     offset_i,
    output logic [TS_W-1:0]     ts_o,
    output logic                pol_o,
    output logic                valid_o
);

    logic [TS_W-1:0] fixed_pt;
    logic [TS_W-1:0] deskewed;

    always_comb begin
        fixed_pt = {coarse_i, frac_i};
        deskewed = fixed_pt + offset_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ts_o    <= '0;
            pol_o   <= 1'b0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= hit_i;
            if (hit_i) begin
                ts_o  <= deskewed;
                pol_o <= pol_i;
            end
        end
    end

endmodule

// File: rtl/edge_timestamper.sv
module edge_timestamper
    import tsenc_pkg::*;
#(
    parameter int CARRY_ELEMS = 8,
    parameter int FRAC_W      = 13,
    parameter int COARSE_W    = 25,
    parameter int LUT_LAT     = 2,
    localparam int TAP_W      = TAPS_PER_ELEM * CARRY_ELEMS,
    localparam int RAW_W      = $clog2(TAP_W + 1),
    localparam int TS_W       = COARSE_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TAP_W-1:0]  taps_i,
    input  logic [TS_W-1:0]   offset_i,
    output logic [RAW_W-1:0]  lut_addr_o,
    output logic              lut_req_o,
    input  logic [FRAC_W-1:0] lut_data_i,
    output logic [TS_W-1:0]   ts_o,
    output logic              ts_pol_o,
    output logic              ts_valid_o
);

    localparam int SIDE_W = COARSE_W + 2;

    logic                hit_s1;
    logic                pol_s1;
    logic [RAW_W-1:0]    raw_s1;
    logic [COARSE_W-1:0] coarse_s1;
    logic [SIDE_W-1:0]   side_in;
    logic [SIDE_W-1:0]   side_out;

    tsenc_edge #(
        .TAP_W (TAP_W),
        .RAW_W (RAW_W)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .taps_i (taps_i),
        .hit_o  (hit_s1),
        .pol_o  (pol_s1),
        .raw_o  (raw_s1)
    );

    tsenc_coarse #(
        .CNT_W (COARSE_W)
    ) u_coarse (
        .clk    (clk),
        .rst_n  (rst_n),
        .snap_o (coarse_s1)
    );

    assign lut_addr_o = raw_s1;
    assign lut_req_o  = hit_s1;
    assign side_in    = {hit_s1, pol_s1, coarse_s1};

    tsenc_align #(
        .DATA_W (SIDE_W),
        .DEPTH  (LUT_LAT)
    ) u_align (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (side_in),
        .q_o   (side_out)
    );

    tsenc_assemble #(
        .COARSE_W (COARSE_W),
        .FRAC_W   (FRAC_W)
    ) u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_i    (side_out[SIDE_W-1]),
        .pol_i    (side_out[SIDE_W-2]),
        .coarse_i (side_out[COARSE_W-1:0]),
        .frac_i   (lut_data_i),
        .offset_i (offset_i),
        .ts_o     (ts_o),
        .pol_o    (ts_pol_o),
        .valid_o  (ts_valid_o)
    );

endmodule

// File: rtl/edge_timestamper_chk.sv
module edge_timestamper_chk #(
    parameter int TAP_W   = 32,
    parameter int RAW_W   = 6,
    parameter int LUT_LAT = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tap0_i,
    input logic             lut_req_o,
    input logic [RAW_W-1:0] lut_addr_o,
    input logic             ts_valid_o,
    input logic             ts_pol_o
);

    logic [7:0]   since_rst;
    logic         tap0_q;
    logic         tap0_qq;
    logic         req_h [LUT_LAT+1];
    logic         pol_h [LUT_LAT+1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
            tap0_q    <= 1'b0;
            tap0_qq   <= 1'b0;
            for (int i = 0; i <= LUT_LAT; i++) begin
                req_h[i] <= 1'b0;
                pol_h[i] <= 1'b0;
            end
        end else begin
            if (since_rst != 8'hFF) since_rst <= since_rst + 1'b1;
            tap0_q   <= tap0_i;
            tap0_qq  <= tap0_q;
            req_h[0] <= lut_req_o;
            pol_h[0] <= tap0_q;
            for (int i = 1; i <= LUT_LAT; i++) begin
                req_h[i] <= req_h[i-1];
                pol_h[i] <= pol_h[i-1];
            end
        end
    end

    // R1
    prime_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst <= 8'd1) |-> !lut_req_o);

    // R1
    prime_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(since_rst) <= LUT_LAT + 2) |-> !ts_valid_o);

    // R2
    edge_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 8'd2) |-> (lut_req_o == (tap0_q != tap0_qq)));

    // R4
    reach_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lut_req_o |-> (lut_addr_o != '0 && int'(lut_addr_o) <= TAP_W));

    // R8
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ts_valid_o == req_h[LUT_LAT]);

    // R3
    polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ts_valid_o |-> (ts_pol_o == pol_h[LUT_LAT]));

endmodule

bind edge_timestamper edge_timestamper_chk #(
    .TAP_W   (TAP_W),
    .RAW_W   (RAW_W),
    .LUT_LAT (LUT_LAT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tap0_i     (taps_i[0]),
    .lut_req_o  (lut_req_o),
    .lut_addr_o (lut_addr_o),
    .ts_valid_o (ts_valid_o),
    .ts_pol_o   (ts_pol_o)
);

// File: tb/tb_edge_timestamper.sv
`timescale 1ns/1ps
module tb_edge_timestamper;

    localparam int CARRY_ELEMS = 8;
    localparam int FRAC_W      = 13;
    localparam int COARSE_W    = 25;
    localparam int LUT_LAT     = 2;
    localparam int TAP_W       = 4 * CARRY_ELEMS;
    localparam int RAW_W       = $clog2(TAP_W + 1);
    localparam int TS_W        = COARSE_W + FRAC_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [TAP_W-1:0]  taps_i = '0;
    logic [TS_W-1:0]   offset_i = '0;
    logic [RAW_W-1:0]  lut_addr_o;
    logic              lut_req_o;
    logic [FRAC_W-1:0] lut_data_i;
    logic [TS_W-1:0]   ts_o;
    logic              ts_pol_o;
    logic              ts_valid_o;

    edge_timestamper #(
        .CARRY_ELEMS (CARRY_ELEMS),
        .FRAC_W      (FRAC_W),
        .COARSE_W    (COARSE_W),
        .LUT_LAT     (LUT_LAT)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .taps_i     (taps_i),
        .offset_i   (offset_i),
        .lut_addr_o (lut_addr_o),
        .lut_req_o  (lut_req_o),
        .lut_data_i (lut_data_i),
        .ts_o       (ts_o),
        .ts_pol_o   (ts_pol_o),
        .ts_valid_o (ts_valid_o)
    );

    always #5 clk = ~clk;

    // Calibration table model with LUT_LAT clocks of latency
    function automatic logic [FRAC_W-1:0] lutf(input int a);
        return FRAC_W'((a * 211 + 7) % (1 << FRAC_W));
    endfunction

    logic [FRAC_W-1:0] lpipe [LUT_LAT];
    always @(posedge clk) begin
        lpipe[0] <= lutf(int'(lut_addr_o));
        for (int i = 1; i < LUT_LAT; i++) lpipe[i] <= lpipe[i-1];
    end
    assign lut_data_i = lpipe[LUT_LAT-1];

    typedef struct {
        int              due;
        logic [TS_W-1:0] ts;
        logic            pol;
        string           tag;
    } exp_t;

    exp_t expq[$];
    int   tests = 0;
    int   fails = 0;
    int   edge_cnt = 0;
    bit   mon_en = 1'b0;
    bit   done = 1'b0;
    logic level = 1'b0;
    int   mon_p;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one snapshot, advance one clock, return its edge index
    task automatic step(input logic [TAP_W-1:0] v, output int idx);
        taps_i = v;
        @(posedge clk);
        idx = edge_cnt;
        edge_cnt++;
        @(negedge clk);
    endtask

    function automatic logic [TAP_W-1:0] mk(input logic nl, input int reach);
        logic [TAP_W-1:0] p;
        for (int i = 0; i < TAP_W; i++) p[i] = (i < reach) ? nl : ~nl;
        return p;
    endfunction

    function automatic void push(input int idx, input int cnt, input logic pol, input string tag);
        exp_t e;
        e.due = idx + LUT_LAT + 1;
        e.ts  = {COARSE_W'(idx), lutf(cnt)} + offset_i;
        e.pol = pol;
        e.tag = tag;
        expq.push_back(e);
    endfunction

    // Output monitor: exact strobe cycle, timestamp and polarity
    always @(negedge clk) begin
        if (mon_en) begin
            mon_p = edge_cnt - 1;
            if (expq.size() > 0 && expq[0].due == mon_p) begin
                tests++;
                if (!ts_valid_o || ts_o !== expq[0].ts || ts_pol_o !== expq[0].pol) begin
                    fails++;
                    $display("FAIL %s: valid=%0b ts=%h pol=%0b expected valid=1 ts=%h pol=%0b",
                             expq[0].tag, ts_valid_o, ts_o, ts_pol_o, expq[0].ts, expq[0].pol);
                end
                void'(expq.pop_front());
            end else if (ts_valid_o) begin
                tests++;
                fails++;
                $display("FAIL R2/R8 spurious strobe: valid=1 ts=%h expected valid=0", ts_o);
            end
        end
    end

    task automatic drain(input string tag);
        int idx;
        repeat (LUT_LAT + 3) step({TAP_W{level}}, idx);
        check(expq.size() == 0, tag, 64'(expq.size()), 64'd0);
    endtask

    // One edge reaching 'reach' taps, followed by a settled snapshot
    task automatic edge_once(input int reach, input string tag);
        int idx;
        logic nl;
        nl = ~level;
        step(mk(nl, reach), idx);
        push(idx, reach, nl, tag);
        check(lut_req_o == 1'b1 && int'(lut_addr_o) == reach, {tag, " R4 address"},
              64'(lut_addr_o), 64'(reach));
        level = nl;
        step({TAP_W{level}}, idx);
    endtask

    task automatic t_prime();
        int idx;
        check(ts_valid_o == 1'b0 && lut_req_o == 1'b0, "R1 reset outputs",
              64'({ts_valid_o, lut_req_o}), 64'd0);
        // First snapshot differs from reset level but must only prime
        step({TAP_W{1'b1}}, idx);
        check(lut_req_o == 1'b0, "R1 prime no request", 64'(lut_req_o), 64'd0);
        level = 1'b1;
        drain("R1 prime no timestamp");
    endtask

    task automatic t_falling_rising();
        edge_once(12, "R3 R5 R6 R8 falling");
        edge_once(20, "R3 R5 R6 R8 rising");
        drain("R3 drain");
    endtask

    task automatic t_reach_bounds();
        edge_once(TAP_W, "R4 full line");
        edge_once(1, "R4 single tap");
        edge_once(4, "R4 one element");
        drain("R4 drain");
    endtask

    task automatic t_bubble();
        int idx;
        logic [TAP_W-1:0] p;
        logic nl;
        nl = ~level;
        p = mk(nl, 20);
        p[5] = ~nl;
        p[9] = ~nl;
        step(p, idx);
        push(idx, 18, nl, "R4 bubble count");
        check(int'(lut_addr_o) == 18, "R4 bubble address", 64'(lut_addr_o), 64'd18);
        level = nl;
        step({TAP_W{level}}, idx);
        drain("R4 bubble drain");
    endtask

    task automatic t_quiet();
        int idx;
        logic [TAP_W-1:0] p;
        p = {TAP_W{level}};
        p[TAP_W-1] = ~level;
        p[7] = ~level;
        step(p, idx);
        check(lut_req_o == 1'b0, "R2 noise off tap 0", 64'(lut_req_o), 64'd0);
        step({TAP_W{level}}, idx);
        check(lut_req_o == 1'b0, "R2 settle", 64'(lut_req_o), 64'd0);
        drain("R2 quiet no timestamp");
    endtask

    task automatic t_back_to_back();
        int idx;
        logic nl;
        nl = ~level;
        step(mk(nl, 8), idx);
        push(idx, 8, nl, "R9 first edge");
        level = nl;
        nl = ~level;
        step(mk(nl, 6), idx);
        push(idx, 6, nl, "R9 second edge");
        level = nl;
        nl = ~level;
        step(mk(nl, 30), idx);
        push(idx, 30, nl, "R9 third edge");
        level = nl;
        step({TAP_W{level}}, idx);
        drain("R9 drain");
    endtask

    task automatic t_offset();
        offset_i = 38'h12_3456_789A;
        edge_once(16, "R7 offset add");
        drain("R7 drain a");
        offset_i = {TS_W{1'b1}};
        edge_once(9, "R7 offset wrap");
        drain("R7 drain b");
        offset_i = '0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mon_en = 1'b1;
        t_prime();
        t_falling_rising();
        t_reach_bounds();
        t_bubble();
        t_quiet();
        t_back_to_back();
        t_offset();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule